// File: doc/BRIEF.md
# SMBus Block Data Buffer

This block stores the payload of SMBus block transfers between a host register port and the SMBus byte engine. The host sees four byte-wide registers behind a two-bit select. One of them is a data window that walks through a 32-entry byte array: every host read or write of the window moves a host-side index forward by one. A read of the control register brings that index back to entry 0. A separate count register holds the block length. The host writes it before a block write, and the engine loads it from the first byte it receives on a block read.

A mode bit in the auxiliary register chooses between two modes. In buffered mode the window auto-increments through the array. In single-byte mode the window is a lone holding byte and the index does not move. The mode is meant for SMBus block transfers only; raw I2C block transfers keep it off.

The engine side has its own pointer, driven by a three-state machine. The states are ENG_IDLE (no transaction), ENG_RUN (transaction open) and ENG_UFLOW (the engine asked for more bytes than the count allows). The transitions are:
- xact_start from any state goes to ENG_RUN and clears the pointer.
- xact_done goes from ENG_RUN or ENG_UFLOW to ENG_IDLE.
- A drain request in ENG_RUN with the pointer at or beyond the effective count goes to ENG_UFLOW.

Top module: `smbus_blkbuf`

## Requirements
- R1: After reset the auxiliary register reads 0, buf_mode is 0 (single-byte mode), the count register reads 0, the data window reads 0 and eng_underflow is 0.
- R2: host_sel encodes 0 = control, 1 = count, 2 = data window, 3 = auxiliary. Bit 1 of the auxiliary register is the buffered-mode enable. It reads back as written and drives buf_mode one cycle after the write. All other auxiliary bits read 0.
- R3: In single-byte mode, data window writes store one holding byte and reads return it. The host index does not move, so buffered access resumes at the same entry.
- R4: In buffered mode, each data window read or write accesses the entry at the host index and then advances the index by one.
- R5: A host read of the control register returns 0 and resets the host index to entry 0.
- R6: The host index stops at 32, one past the last entry. Once it is there, window writes change nothing and window reads return 0.
- R7: The host can write the count register and read it back.
- R8: xact_start moves the engine to ENG_RUN and resets its pointer. In buffered mode each drain (eng_rd) presents the entry at the pointer on eng_rdata and then advances the pointer.
- R9: In ENG_RUN each fill (eng_wr) writes the entry at the engine pointer and advances the pointer. eng_cnt_wr loads the count register. The host can read both back.
- R10: In buffered mode, a drain with the pointer at or beyond the count (counts above 32 act as 32) raises eng_underflow. The flag stays set until xact_start or xact_done.
- R11: In ENG_IDLE, eng_rd and eng_wr have no effect on the buffer or the flag. xact_done clears eng_underflow.
- R12: When host and engine write the same entry in the same cycle, the engine's byte is stored. When both write the count in the same cycle, the engine's value is stored.
- R13: In single-byte mode, engine fills and drains use the holding byte that the host window sees.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Host register select |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (side effects on the clock edge) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register |
| xact_start | input | 1 | Engine transaction start |
| xact_done | input | 1 | Engine transaction end |
| eng_wr | input | 1 | Engine fill strobe |
| eng_wdata | input | 8 | Engine fill byte |
| eng_rd | input | 1 | Engine drain strobe |
| eng_rdata | output | 8 | Byte at the engine pointer (or holding byte) |
| eng_cnt_wr | input | 1 | Engine load of the count register |
| eng_cnt_data | input | 8 | Count value received by the engine |
| eng_count | output | 8 | Current count register value |
| buf_mode | output | 1 | Buffered mode enabled |
| eng_underflow | output | 1 | Engine asked for more bytes than the count |

## Verification
The assertions check on every cycle the rules that depend only on timing. They cover the mode bit following an auxiliary write, the host index returning to 0 after a control read and staying within its end stop, and the index holding still in single-byte mode. They also cover the underflow flag being cleared by transaction start and end and otherwise staying set. Only the bench's scenarios can show that the right byte sits in the right entry. That covers write-then-readback order, an extra write past the end being dropped, engine drains returning host-written data, and engine fills being visible to the host. It also covers the write priority when host and engine collide, and the count clamp at 32 that moves the underflow point.

// File: rtl/smbb_pkg.sv
package smbb_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_DATA  = 2'd2,
        SEL_AUX   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_RUN   = 2'd1,
        ENG_UFLOW = 2'd2
    } eng_state_e;

    localparam int MODE_BIT = 1;
endpackage

// File: rtl/smbb_host_port.sv
module smbb_host_port
    import smbb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    host_sel,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          eng_cnt_wr,
    input  logic [DW-1:0] eng_cnt_data,
    input  logic [DW-1:0] win_rdata,
    output logic          mode_en,
    output logic [DW-1:0] count_q,
    output logic [IW-1:0] hidx_q,
    output logic          win_we
);
    reg_sel_e sel;
    logic     win_access;
    logic     idx_room;

    always_comb begin
        sel        = reg_sel_e'(host_sel);
        win_access = (host_rd || host_wr) && (sel == SEL_DATA);
        idx_room   = (hidx_q < IW'(DEPTH));
        win_we     = host_wr && (sel == SEL_DATA) && (!mode_en || idx_room);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_en <= 1'b0;
            count_q <= '0;
            hidx_q  <= '0;
        end else begin
            if (host_wr && sel == SEL_AUX)
                mode_en <= host_wdata[MODE_BIT];
            if (eng_cnt_wr)
                count_q <= eng_cnt_data;
            else if (host_wr && sel == SEL_COUNT)
                count_q <= host_wdata;
            if (host_rd && sel == SEL_CTRL)
                hidx_q <= '0;
            else if (win_access && mode_en && idx_room)
                hidx_q <= hidx_q + IW'(1);
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (sel)
            SEL_CTRL:  host_rdata = '0;
            SEL_COUNT: host_rdata = count_q;
            SEL_DATA:  host_rdata = win_rdata;
            SEL_AUX:   host_rdata[MODE_BIT] = mode_en;
            default:   host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/smbb_store.sv
module smbb_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int IW    = 6,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_en,
    input  logic          h_we,
    input  logic [IW-1:0] h_idx,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic          e_we,
    input  logic [IW-1:0] e_idx,
    input  logic [DW-1:0] e_wdata,
    output logic [DW-1:0] e_rdata
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] hold_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (mode_en && e_we && e_idx == IW'(g))
                mem[g] <= e_wdata;
            else if (mode_en && h_we && h_idx == IW'(g))
                mem[g] <= h_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_q <= '0;
        else if (!mode_en && e_we)
            hold_q <= e_wdata;
        else if (!mode_en && h_we)
            hold_q <= h_wdata;
    end

    always_comb begin
        if (!mode_en)
            h_rdata = hold_q;
        else if (h_idx < IW'(DEPTH))
            h_rdata = mem[h_idx[AW-1:0]];
        else
            h_rdata = '0;
        if (!mode_en)
            e_rdata = hold_q;
        else if (e_idx < IW'(DEPTH))
            e_rdata = mem[e_idx[AW-1:0]];
        else
            e_rdata = '0;
    end
endmodule

// File: rtl/smbb_engine_fsm.sv
module smbb_engine_fsm
    import smbb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int IW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_en,
    input  logic [DW-1:0] count,
    input  logic          xact_start,
    input  logic          xact_done,
    input  logic          eng_rd,
    input  logic          eng_wr,
    output logic [IW-1:0] eptr_q,
    output logic          fill_we,
    output logic          underflow
);
    eng_state_e    state_q, state_d;
    logic [IW-1:0] eptr_d;
    logic [IW-1:0] limit;
    logic          over;

    always_comb begin
        limit = (count > DW'(DEPTH)) ? IW'(DEPTH) : IW'(count);
        over  = (eptr_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            eptr_q  <= '0;
        end else begin
            state_q <= state_d;
            eptr_q  <= eptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        eptr_d  = eptr_q;
        unique case (state_q)
            ENG_IDLE: begin
                if (xact_start) begin
                    state_d = ENG_RUN;
                    eptr_d  = '0;
                end
            end
            ENG_RUN: begin
                if (xact_start)
                    eptr_d = '0;
                else if (xact_done)
                    state_d = ENG_IDLE;
                else if (mode_en) begin
                    if (eng_rd && over)
                        state_d = ENG_UFLOW;
                    else if (eng_rd || (eng_wr && eptr_q < IW'(DEPTH)))
                        eptr_d = eptr_q + IW'(1);
                end
            end
            ENG_UFLOW: begin
                if (xact_start) begin
                    state_d = ENG_RUN;
                    eptr_d  = '0;
                end else if (xact_done)
                    state_d = ENG_IDLE;
            end
            default: state_d = ENG_IDLE;
        endcase
    end

    always_comb begin
        underflow = (state_q == ENG_UFLOW);
        fill_we   = (state_q == ENG_RUN) && eng_wr && !xact_start && !xact_done
                    && (!mode_en || eptr_q < IW'(DEPTH));
    end
endmodule

// File: rtl/smbus_blkbuf.sv
module smbus_blkbuf #(
    parameter int DEPTH = 32,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    host_sel,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          xact_start,
    input  logic          xact_done,
    input  logic          eng_wr,
    input  logic [DW-1:0] eng_wdata,
    input  logic          eng_rd,
    output logic [DW-1:0] eng_rdata,
    input  logic          eng_cnt_wr,
    input  logic [DW-1:0] eng_cnt_data,
    output logic [DW-1:0] eng_count,
    output logic          buf_mode,
    output logic          eng_underflow
);
    localparam int IW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);

    logic          mode_en;
    logic [DW-1:0] count_q;
    logic [IW-1:0] host_idx;
    logic [IW-1:0] eng_ptr;
    logic          win_we;
    logic          fill_we;
    logic [DW-1:0] win_rdata;

    smbb_host_port #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_host (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .eng_cnt_wr(eng_cnt_wr), .eng_cnt_data(eng_cnt_data),
        .win_rdata(win_rdata), .mode_en(mode_en), .count_q(count_q),
        .hidx_q(host_idx), .win_we(win_we)
    );

    smbb_engine_fsm #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_eng (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .count(count_q),
        .xact_start(xact_start), .xact_done(xact_done), .eng_rd(eng_rd),
        .eng_wr(eng_wr), .eptr_q(eng_ptr), .fill_we(fill_we),
        .underflow(eng_underflow)
    );

    smbb_store #(.DEPTH(DEPTH), .DW(DW), .IW(IW), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en),
        .h_we(win_we), .h_idx(host_idx), .h_wdata(host_wdata), .h_rdata(win_rdata),
        .e_we(fill_we), .e_idx(eng_ptr), .e_wdata(eng_wdata), .e_rdata(eng_rdata)
    );

    assign eng_count = count_q;
    assign buf_mode  = mode_en;
endmodule

// File: rtl/smbus_blkbuf_chk.sv
module smbus_blkbuf_chk #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int IW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    host_sel,
    input logic          host_wr,
    input logic          host_rd,
    input logic [DW-1:0] host_wdata,
    input logic          xact_start,
    input logic          xact_done,
    input logic          buf_mode,
    input logic          eng_underflow,
    input logic [IW-1:0] host_idx
);
    // R2
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'd3) |=> (buf_mode == $past(host_wdata[1])));

    // R5
    ctrl_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_sel == 2'd0) |=> (host_idx == '0));

    // R6
    idx_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_idx <= IW'(DEPTH));

    // R3
    single_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_mode && (host_rd || host_wr) && host_sel == 2'd2) |=> $stable(host_idx));

    // R8
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xact_start |=> !eng_underflow);

    // R10
    uflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_underflow && !xact_start && !xact_done) |=> eng_underflow);

    // R11
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xact_done |=> !eng_underflow);
endmodule

bind smbus_blkbuf smbus_blkbuf_chk #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .xact_start(xact_start),
    .xact_done(xact_done), .buf_mode(buf_mode), .eng_underflow(eng_underflow),
    .host_idx(host_idx)
);

// File: tb/smbus_blkbuf_test.sv
module smbus_blkbuf_test;
    localparam int DEPTH = 32;
    localparam int DW    = 8;
    localparam logic [1:0] S_CTRL = 2'd0, S_CNT = 2'd1, S_DATA = 2'd2, S_AUX = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    host_sel = '0;
    logic          host_wr = 1'b0, host_rd = 1'b0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic          xact_start = 1'b0, xact_done = 1'b0;
    logic          eng_wr = 1'b0, eng_rd = 1'b0, eng_cnt_wr = 1'b0;
    logic [DW-1:0] eng_wdata = '0, eng_cnt_data = '0;
    logic [DW-1:0] eng_rdata, eng_count;
    logic          buf_mode, eng_underflow;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] v;

    always #10 clk = ~clk;

    smbus_blkbuf #(.DEPTH(DEPTH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .xact_start(xact_start), .xact_done(xact_done), .eng_wr(eng_wr),
        .eng_wdata(eng_wdata), .eng_rd(eng_rd), .eng_rdata(eng_rdata),
        .eng_cnt_wr(eng_cnt_wr), .eng_cnt_data(eng_cnt_data), .eng_count(eng_count),
        .buf_mode(buf_mode), .eng_underflow(eng_underflow)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] s, input logic [DW-1:0] d);
        @(negedge clk); host_sel = s; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] s, output logic [DW-1:0] d);
        @(negedge clk); host_sel = s; host_rd = 1'b1;
        #5 d = host_rdata;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); xact_start = 1'b1;
        @(negedge clk); xact_start = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); xact_done = 1'b1;
        @(negedge clk); xact_done = 1'b0;
    endtask

    task automatic ewrite(input logic [DW-1:0] d);
        @(negedge clk); eng_wdata = d; eng_wr = 1'b1;
        @(negedge clk); eng_wr = 1'b0;
    endtask

    task automatic eread(output logic [DW-1:0] d);
        @(negedge clk); eng_rd = 1'b1;
        #5 d = eng_rdata;
        @(negedge clk); eng_rd = 1'b0;
    endtask

    task automatic t_reset();
        hread(S_AUX, v);  check("R1 aux", v, 8'h00);
        hread(S_CNT, v);  check("R1 count", v, 8'h00);
        hread(S_DATA, v); check("R1 window", v, 8'h00);
        check("R1 buf_mode", {7'b0, buf_mode}, 8'h00);
        check("R1 underflow", {7'b0, eng_underflow}, 8'h00);
    endtask

    task automatic t_aux();
        hwrite(S_AUX, 8'hFF);
        hread(S_AUX, v); check("R2 aux readback set", v, 8'h02);
        check("R2 buf_mode set", {7'b0, buf_mode}, 8'h01);
        hwrite(S_AUX, 8'hFD);
        hread(S_AUX, v); check("R2 aux readback clear", v, 8'h00);
        check("R2 buf_mode clear", {7'b0, buf_mode}, 8'h00);
    endtask

    task automatic t_single();
        hwrite(S_AUX, 8'h02);
        hread(S_CTRL, v); check("R5 ctrl reads zero", v, 8'h00);
        hwrite(S_DATA, 8'hA1);
        hwrite(S_DATA, 8'hA2);
        hwrite(S_AUX, 8'h00);
        hwrite(S_DATA, 8'h55);
        hread(S_DATA, v); check("R3 hold read 1", v, 8'h55);
        hread(S_DATA, v); check("R3 hold read 2", v, 8'h55);
        hwrite(S_AUX, 8'h02);
        hwrite(S_DATA, 8'hA3);
        hread(S_CTRL, v);
        hread(S_DATA, v); check("R3 entry0", v, 8'hA1);
        hread(S_DATA, v); check("R3 entry1", v, 8'hA2);
        hread(S_DATA, v); check("R3 index held", v, 8'hA3);
        hread(S_CTRL, v);
        hread(S_DATA, v); check("R5 rewind", v, 8'hA1);
    endtask

    task automatic t_buffered();
        hread(S_CTRL, v);
        for (int i = 0; i < DEPTH; i++) hwrite(S_DATA, 8'(i * 3 + 7));
        hwrite(S_DATA, 8'hEE);
        hread(S_DATA, v); check("R6 read past end", v, 8'h00);
        hread(S_CTRL, v);
        for (int i = 0; i < DEPTH; i++) begin
            hread(S_DATA, v); check("R4 readback", v, 8'(i * 3 + 7));
        end
        hread(S_DATA, v); check("R6 still past end", v, 8'h00);
    endtask

    task automatic t_count();
        hwrite(S_CNT, 8'h05);
        hread(S_CNT, v); check("R7 count", v, 8'h05);
        check("R7 eng_count", eng_count, 8'h05);
    endtask

    task automatic t_drain();
        hwrite(S_CNT, 8'd3);
        pulse_start();
        check("R8 no underflow after start", {7'b0, eng_underflow}, 8'h00);
        for (int i = 0; i < 3; i++) begin
            eread(v); check("R8 drain", v, 8'(i * 3 + 7));
        end
        check("R10 no underflow within count", {7'b0, eng_underflow}, 8'h00);
        eread(v);
        check("R10 underflow raised", {7'b0, eng_underflow}, 8'h01);
        eread(v);
        check("R10 underflow held", {7'b0, eng_underflow}, 8'h01);
        pulse_start();
        check("R8 start clears underflow", {7'b0, eng_underflow}, 8'h00);
        eread(v); check("R8 pointer reset", v, 8'd7);
        pulse_done();
        hwrite(S_CNT, 8'd40);
        pulse_start();
        for (int i = 0; i < DEPTH; i++) eread(v);
        check("R10 clamp no underflow at 32", {7'b0, eng_underflow}, 8'h00);
        eread(v);
        check("R10 clamp underflow at 33", {7'b0, eng_underflow}, 8'h01);
        pulse_done();
        check("R11 done clears underflow", {7'b0, eng_underflow}, 8'h00);
        hwrite(S_CNT, 8'd0);
        pulse_start();
        eread(v);
        check("R10 zero count underflow", {7'b0, eng_underflow}, 8'h01);
        pulse_done();
    endtask

    task automatic t_idle();
        ewrite(8'h99);
        eread(v);
        check("R11 idle no underflow", {7'b0, eng_underflow}, 8'h00);
        hread(S_CTRL, v);
        hread(S_DATA, v); check("R11 idle fill ignored", v, 8'd7);
    endtask

    task automatic t_fill();
        pulse_start();
        @(negedge clk); eng_cnt_data = 8'd4; eng_cnt_wr = 1'b1;
        @(negedge clk); eng_cnt_wr = 1'b0;
        for (int i = 0; i < 4; i++) ewrite(8'hC0 + 8'(i));
        pulse_done();
        hread(S_CNT, v); check("R9 count from engine", v, 8'd4);
        hread(S_CTRL, v);
        for (int i = 0; i < 4; i++) begin
            hread(S_DATA, v); check("R9 filled entry", v, 8'hC0 + 8'(i));
        end
    endtask

    task automatic t_collide();
        pulse_start();
        hread(S_CTRL, v);
        @(negedge clk);
        host_sel = S_DATA; host_wdata = 8'h11; host_wr = 1'b1;
        eng_wdata = 8'h22; eng_wr = 1'b1;
        @(negedge clk);
        host_sel = S_CNT; host_wdata = 8'h05; host_wr = 1'b1;
        eng_wr = 1'b0; eng_cnt_data = 8'h09; eng_cnt_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; eng_cnt_wr = 1'b0;
        pulse_done();
        hread(S_CTRL, v);
        hread(S_DATA, v); check("R12 engine wins entry", v, 8'h22);
        hread(S_CNT, v);  check("R12 engine wins count", v, 8'h09);
    endtask

    task automatic t_single_engine();
        hwrite(S_AUX, 8'h00);
        pulse_start();
        ewrite(8'h77);
        hread(S_DATA, v); check("R13 host sees engine byte", v, 8'h77);
        hwrite(S_DATA, 8'h66);
        eread(v); check("R13 engine sees host byte", v, 8'h66);
        pulse_done();
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_aux();
        t_single();
        t_buffered();
        t_count();
        t_drain();
        t_idle();
        t_fill();
        t_collide();
        t_single_engine();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule